// File: doc/BRIEF.md
# Standby entry and wake controller

This block decides when a small processor core drops into a low-power standby state and when it comes back out. Software requests standby by writing a nonzero mode code through a write strobe. The block checks that the system clock has finished any mode switch and that no interrupt request above the lowest level is pending. It then counts a fixed entry window during which the core keeps running. After the window it asserts a halt/clock-gate output.

While in standby, any request above the lowest level releases the core, whatever the core's interrupt-enable flag and level mask say. The release is marked by a one-cycle wake pulse. In that cycle the block also tells the core whether to vector to the interrupt or to resume at the instruction after the one that requested standby. That choice is made against the core's enable flag and mask.

Each request carries a 2-bit level, where a smaller code is more urgent. Code 2'b11 is the lowest level and never blocks or wakes. Among several active requests, the most urgent one decides.

Top module: `stby_ctl`

## Requirements
- R1: After a synchronous reset the block is idle: `halt`, `stby_active`, `wake`, `take_irq`, `resume_next` and `mode_err` are all 0, and `stby_mode_q` is 0.
- R2: An accepted standby write (nonzero `stby_mode`, `clk_mon` equal to `clk_sel`, no request above level 2'b11) sets `stby_active` and latches the mode into `stby_mode_q` from the next cycle. `halt` rises exactly ENTRY_CYC (default 4) cycles after the write edge and stays low before that.
- R3: A standby write with `stby_mode` equal to 0 has no effect.
- R4: A standby write is discarded while any active request has a level code 0, 1 or 2. This holds whatever `cpu_ie` and `cpu_ilm` are. Active requests at level 2'b11 do not block entry.
- R5: A discarded write is not remembered. Once the blocking request goes away, the block stays idle.
- R6: A standby write made while `clk_mon` differs from `clk_sel` is ignored and sets `mode_err`. `mode_err` stays set until reset.
- R7: A request above level 2'b11 during the entry window cancels entry. `stby_active` drops on the next cycle and `halt` is never asserted.
- R8: In standby, a request above level 2'b11 releases the core. On the next edge `halt` falls and `wake` is high for exactly one cycle, after which the block is idle. Requests at level 2'b11 do not release it.
- R9: During the wake cycle exactly one of `take_irq` and `resume_next` is high. `take_irq` is high when `cpu_ie` is 1 and the winning level code is numerically below `cpu_ilm`, both sampled at the release edge.
- R10: The winning level is the smallest level code among the active requests. Request i takes its level from `irq_lvl[2*i+1:2*i]`.
- R11: Standby writes made while entering or in standby are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous reset, active high |
| stby_wr | input | 1 | Standby register write strobe |
| stby_mode | input | 2 | Written standby mode code, 0 means none |
| irq_req | input | NIRQ | Peripheral interrupt requests |
| irq_lvl | input | 2*NIRQ | Per-request 2-bit level, 0 most urgent |
| cpu_ie | input | 1 | Core interrupt-enable flag |
| cpu_ilm | input | 2 | Core level mask; levels below it are accepted |
| clk_sel | input | 2 | Clock-mode setting field |
| clk_mon | input | 2 | Clock-mode monitor field |
| halt | output | 1 | Core halt / clock gate |
| stby_active | output | 1 | Entering or in standby |
| wake | output | 1 | One-cycle release pulse |
| take_irq | output | 1 | Core should service the interrupt |
| resume_next | output | 1 | Core should resume at next instruction |
| mode_err | output | 1 | Sticky: write made during clock switch |
| stby_mode_q | output | 2 | Mode currently being entered or held |

## Verification
A write or a decision sampled at edge E shows on `stby_active`, `mode_err` and `stby_mode_q` just after E. `halt` rises just after E+4. A release request sampled at E drops `halt` and raises `wake`, `take_irq` or `resume_next` just after E, and they fall again after E+1. The bench changes inputs and samples outputs a short delay after each rising edge and counts edges itself, so every check lands in the cycle worked out above. A sweep over both requests' levels, the enable flag and every mask value computes the wake and service outcome arithmetically.

// File: rtl/stby_ctl.sv
module stby_ctl #(
  parameter int NIRQ      = 4,
  parameter int ENTRY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stby_wr,
  input  logic [1:0]        stby_mode,
  input  logic [NIRQ-1:0]   irq_req,
  input  logic [2*NIRQ-1:0] irq_lvl,
  input  logic              cpu_ie,
  input  logic [1:0]        cpu_ilm,
  input  logic [1:0]        clk_sel,
  input  logic [1:0]        clk_mon,
  output logic              halt,
  output logic              stby_active,
  output logic              wake,
  output logic              take_irq,
  output logic              resume_next,
  output logic              mode_err,
  output logic [1:0]        stby_mode_q
);
  localparam int CW = (ENTRY_CYC > 2) ? $clog2(ENTRY_CYC) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(ENTRY_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ENTER, ST_STBY, ST_WAKE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          acc_q;
  logic [1:0]    best_lvl;

  always_comb begin
    best_lvl = 2'b11;
    for (int i = 0; i < NIRQ; i++)
      if (irq_req[i] && irq_lvl[2*i +: 2] < best_lvl)
        best_lvl = irq_lvl[2*i +: 2];
  end

  wire hi_pend = (best_lvl != 2'b11);
  wire clk_ok  = (clk_sel == clk_mon);
  wire wr_go   = stby_wr && (stby_mode != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      acc_q       <= 1'b0;
      mode_err    <= 1'b0;
      stby_mode_q <= 2'b00;
    end else begin
      case (st)
        ST_IDLE:
          if (wr_go) begin
            if (!clk_ok) mode_err <= 1'b1;
            else if (!hi_pend) begin
              st          <= ST_ENTER;
              cnt         <= CNT_LOAD;
              stby_mode_q <= stby_mode;
            end
          end
        ST_ENTER:
          if (hi_pend) begin
            st          <= ST_IDLE;
            stby_mode_q <= 2'b00;
          end else if (cnt == '0) st <= ST_STBY;
          else cnt <= cnt - 1'b1;
        ST_STBY:
          if (hi_pend) begin
            st    <= ST_WAKE;
            acc_q <= cpu_ie && (best_lvl < cpu_ilm);
          end
        default: begin
          st          <= ST_IDLE;
          stby_mode_q <= 2'b00;
        end
      endcase
    end
  end

  assign halt        = (st == ST_STBY);
  assign stby_active = (st == ST_ENTER) || (st == ST_STBY);
  assign wake        = (st == ST_WAKE);
  assign take_irq    = wake && acc_q;
  assign resume_next = wake && !acc_q;

  a_r2_halt_from_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(halt) |-> $past(st) == ST_ENTER);
  a_r7_cancel_no_halt: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ENTER && hi_pend) |=> !halt && !stby_active);
  a_r8_wake_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake && !halt);
  a_r8_wake_after_halt: assert property (@(posedge clk) disable iff (rst)
    $rose(wake) |-> !halt && $past(halt));
  a_r8_low_level_holds: assert property (@(posedge clk) disable iff (rst)
    (halt && !hi_pend) |=> halt);
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
    (wake |-> (take_irq != resume_next)) and (!wake |-> !take_irq && !resume_next));
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    mode_err |=> mode_err);
endmodule

// File: tb/test_stby_ctl.sv
module test_stby_ctl;
  localparam int NI = 4;
  logic clk = 0, rst = 1;
  logic stby_wr = 0;
  logic [1:0] stby_mode = 0;
  logic [NI-1:0] irq_req = 0;
  logic [2*NI-1:0] irq_lvl = '1;
  logic cpu_ie = 0;
  logic [1:0] cpu_ilm = 0, clk_sel = 0, clk_mon = 0;
  logic halt, stby_active, wake, take_irq, resume_next, mode_err;
  logic [1:0] stby_mode_q;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stby_ctl #(.NIRQ(NI), .ENTRY_CYC(4)) i_stby_ctl (
    .clk(clk), .rst(rst), .stby_wr(stby_wr), .stby_mode(stby_mode),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .cpu_ie(cpu_ie), .cpu_ilm(cpu_ilm),
    .clk_sel(clk_sel), .clk_mon(clk_mon), .halt(halt), .stby_active(stby_active),
    .wake(wake), .take_irq(take_irq), .resume_next(resume_next),
    .mode_err(mode_err), .stby_mode_q(stby_mode_q));

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic set_irq(int i, bit en, logic [1:0] lvl);
    irq_req[i] = en;
    irq_lvl[2*i +: 2] = lvl;
  endtask

  task automatic write(logic [1:0] m);
    stby_wr = 1; stby_mode = m;
    step();
    stby_wr = 0; stby_mode = 0;
  endtask

  task automatic enter_ok();
    write(2'd1);
    step(4);
    chk("R2 halt reached", halt, 1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst = 0;
    chk("R1 halt", halt, 0);
    chk("R1 stby_active", stby_active, 0);
    chk("R1 wake", wake, 0);
    chk("R1 take_irq", take_irq, 0);
    chk("R1 resume_next", resume_next, 0);
    chk("R1 mode_err", mode_err, 0);
    chk("R1 mode", stby_mode_q, 0);

    write(2'd2);
    chk("R2 active", stby_active, 1);
    chk("R2 mode latched", stby_mode_q, 2);
    for (int k = 0; k < 3; k++) begin
      chk("R2 halt early", halt, 0);
      step();
    end
    chk("R2 halt still low at E3", halt, 0);
    step();
    chk("R2 halt at E4", halt, 1);

    write(2'd1);
    chk("R11 write in standby halt", halt, 1);
    chk("R11 mode kept", stby_mode_q, 2);
    set_irq(0, 1, 2'b11);
    step(2);
    chk("R8 level3 no wake", halt, 1);
    chk("R8 level3 no pulse", wake, 0);
    set_irq(1, 1, 2'b01); cpu_ie = 0; cpu_ilm = 2'b11;
    step();
    chk("R8 halt released", halt, 0);
    chk("R8 wake pulse", wake, 1);
    chk("R9 resume with ie=0", resume_next, 1);
    chk("R9 no take with ie=0", take_irq, 0);
    step();
    chk("R8 wake one cycle", wake, 0);
    chk("R8 idle after wake", stby_active, 0);
    irq_req = 0;

    write(2'd0);
    step(5);
    chk("R3 mode 0 ignored", stby_active, 0);
    chk("R3 mode 0 halt", halt, 0);

    for (int l = 0; l < 3; l++)
      for (int ie = 0; ie < 2; ie++) begin
        cpu_ie = ie[0]; cpu_ilm = 2'b00;
        set_irq(2, 1, l[1:0]);
        write(2'd1);
        chk("R4 pending discards", stby_active, 0);
        set_irq(2, 0, 2'b11);
        step(5);
        chk("R5 not remembered active", stby_active, 0);
        chk("R5 not remembered halt", halt, 0);
      end

    set_irq(3, 1, 2'b11);
    write(2'd3);
    chk("R4 level3 does not block", stby_active, 1);
    step();
    set_irq(0, 1, 2'b10);
    step();
    chk("R7 cancel active", stby_active, 0);
    chk("R7 cancel mode", stby_mode_q, 0);
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R7 halt never", halt, 0);
    end
    irq_req = 0;

    write(2'd1);
    step(2);
    write(2'd2);
    step();
    chk("R11 write while entering", stby_mode_q, 1);
    chk("R11 entry not restarted", halt, 1);
    set_irq(0, 1, 2'b00);
    step(2);
    irq_req = 0;

    clk_sel = 2'b01; clk_mon = 2'b00;
    write(2'd1);
    chk("R6 mismatch ignored", stby_active, 0);
    chk("R6 err set", mode_err, 1);
    clk_mon = 2'b01;
    step(5);
    chk("R6 err sticky", mode_err, 1);
    chk("R6 still idle", halt, 0);

    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int ie = 0; ie < 2; ie++)
          for (int m = 0; m < 4; m++) begin
            int best;
            irq_req = 0; cpu_ie = ie[0]; cpu_ilm = m[1:0];
            enter_ok();
            set_irq(0, 1, a[1:0]);
            set_irq(1, 1, b[1:0]);
            best = (a < b) ? a : b;
            step();
            chk("R10 wake by best level", wake, best < 3);
            if (best < 3) begin
              chk("R9 take", take_irq, (ie == 1) && (best < m));
              chk("R9 resume", resume_next, !((ie == 1) && (best < m)));
              step();
            end else begin
              chk("R10 level3 pair holds halt", halt, 1);
              set_irq(2, 1, 2'b00);
              step(2);
            end
            irq_req = 0;
            step();
            chk("R8 idle after sweep wake", stby_active, 0);
          end

    rst = 1;
    step();
    rst = 0;
    chk("R1 err cleared by reset", mode_err, 0);
    done = 1;
    finish_run();
  end
endmodule